// File: doc/BRIEF.md
# Shared-Resource 32-bit Arithmetic and Logic Unit

This block is a purely combinational 32-bit arithmetic and logic unit for a processor datapath. Two 32-bit operands, a 4-bit operation code and a 5-bit shift count go in. A 32-bit result and a signed-overflow flag come out in the same cycle. The operation set covers three shifts, addition, subtraction, four bitwise operations and four comparisons that yield 0 or 1.

Area is kept low by sharing hardware. One adder, with an inverted operand and a carry-in, performs both add and subtract. One left shifter with a fill input performs all three shifts. Right shifts reverse the bit order on the way into the shifter and again on the way out. Decoding is done in small stages keyed on individual opcode bits, not through a wide multiplexer or a full one-hot decoder. Some opcode bits are don't-care for some groups, so two codes can select the same operation.

Top module: `alu32_shared`

## Requirements
- R1: Opcodes 0000 and 0001 give C = B shifted left by the shift count, with zeros entering at bit 0, and V = 0.
- R2: Opcodes 0010 and 0011 give C = A + B modulo 2^32. V is 1 exactly when the operands have the same sign and the result's sign differs from it.
- R3: Opcodes 0110 and 0111 give C = A - B modulo 2^32. V is 1 exactly when the operands have different signs and the result's sign differs from the sign of A.
- R4: Opcode 0100 gives C = B shifted right by the shift count, with zeros entering at bit 31.
- R5: Opcode 0101 gives C = B shifted right by the shift count, with copies of B[31] entering at the top.
- R6: Opcode 1000 gives A AND B, 1010 gives A OR B, 1100 gives A XOR B, and 1110 gives NOT (A OR B).
- R7: Opcode 1011 gives C = 1 when A equals B and 0 otherwise. Opcode 1001 gives C = 1 when A differs from B and 0 otherwise.
- R8: Opcode 1111 gives C = 1 when A, read as signed, is greater than zero. Opcode 1101 gives C = 1 when A is less than or equal to zero. Each gives 0 otherwise.
- R9: For every comparison, C[31:1] is zero and the outcome is in C[0]. V is 0 for every opcode outside 001x and 011x.
- R10: For the pairs 000x, 001x and 011x, C and V are identical for both values of opcode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B; the value that is shifted |
| op_i | input | 4 | Operation code |
| shamt_i | input | 5 | Shift count, unsigned 0 to 31 |
| result_o | output | 32 | Result C |
| ovf_o | output | 1 | Signed overflow flag V |

## Verification
The bench builds the block at its default width of 32 bits with a 5-bit shift count. At that width, every shift count from 0 to 31 can be exercised exhaustively for all three shifts. Every pairing of the corner operands 0, +1, -1, the largest positive value and the most negative value can be driven through the add, subtract and compare paths. Every one of the sixteen opcode values can be applied, so both settings of each don't-care bit are compared against each other.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  // Operation groups, picked from a few opcode bits only
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_ARITH = 2'd1,
    GRP_BITOP = 2'd2,
    GRP_TEST  = 2'd3
  } op_grp_e;

  // Stage one of decoding: bit 3 splits datapath from logic/test,
  // then bit 1 (low half) or bit 0 (high half) picks the group.
  function automatic op_grp_e op_group(input logic [3:0] op);
    if (op[3]) return op[0] ? GRP_TEST : GRP_BITOP;
    else       return op[1] ? GRP_ARITH : GRP_SHIFT;
  endfunction

  // Subtract when bit 2 is set inside the arithmetic group
  function automatic logic op_is_sub(input logic [3:0] op);
    return op[2];
  endfunction

  // Right shift when bit 2 is set inside the shift group
  function automatic logic op_is_right(input logic [3:0] op);
    return op[2];
  endfunction

  // Sign fill requested by bit 0 inside the right-shift pair
  function automatic logic op_is_arith_fill(input logic [3:0] op);
    return op[0];
  endfunction

endpackage

// File: rtl/alu_lshift.sv
module alu_lshift #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              fill,
  output logic [DATA_W-1:0] dout
);
  localparam int NSTAGE = AMT_W;

  logic [DATA_W-1:0] stage [NSTAGE+1];

  assign stage[0] = din;

  // Log-depth barrel: stage k moves by 2**k when amt[k] is set
  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][DATA_W-1-DIST:0], {DIST{fill}}}
                               : stage[k];
  end

  assign dout = stage[NSTAGE];
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] b,
  input  logic [AMT_W-1:0]  amt,
  input  logic              go_right,
  input  logic              sign_fill,
  output logic [DATA_W-1:0] shifted
);
  logic [DATA_W-1:0] b_rev;
  logic [DATA_W-1:0] core_in;
  logic [DATA_W-1:0] core_out;
  logic [DATA_W-1:0] core_rev;
  logic              fill_bit;

  // Bit reversal is pure wiring
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign b_rev[i]    = b[DATA_W-1-i];
    assign core_rev[i] = core_out[DATA_W-1-i];
  end

  assign core_in  = go_right ? b_rev : b;
  assign fill_bit = go_right & sign_fill & b[DATA_W-1];

  alu_lshift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_lsh (
    .din  (core_in),
    .amt  (amt),
    .fill (fill_bit),
    .dout (core_out)
  );

  assign shifted = go_right ? core_rev : core_out;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              carry_into_msb,
  output logic              carry_out,
  output logic              ovf
);
  localparam int LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [LOW_W:0]    low_part;
  logic [1:0]        top_part;

  // Subtraction: invert B and inject a carry of one
  assign b_eff = b ^ {DATA_W{sub}};

  assign low_part = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                  + {{LOW_W{1'b0}}, sub};
  assign carry_into_msb = low_part[LOW_W];
  assign top_part = {1'b0, a[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]}
                  + {1'b0, carry_into_msb};
  assign carry_out = top_part[1];

  assign sum = {top_part[0], low_part[LOW_W-1:0]};
  assign ovf = carry_into_msb ^ carry_out;
endmodule

// File: rtl/alu_logic_test.sv
module alu_logic_test #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        sel,
  input  logic              is_test,
  output logic [DATA_W-1:0] out
);
  logic [DATA_W-1:0] diff_bits;
  logic [DATA_W-1:0] bit_res;
  logic              same;
  logic              above_zero;
  logic              raw_hit;
  logic              hit;

  assign diff_bits = a ^ b;

  always_comb begin
    unique case (sel)
      2'b00:   bit_res = a & b;
      2'b01:   bit_res = a | b;
      2'b10:   bit_res = diff_bits;
      default: bit_res = ~(a | b);
    endcase
  end

  // sel[1] picks the zero test over equality; sel[0] keeps or inverts it
  assign same       = ~|diff_bits;
  assign above_zero = ~a[DATA_W-1] & (|a);
  assign raw_hit    = sel[1] ? above_zero : same;
  assign hit        = sel[0] ? raw_hit : ~raw_hit;

  assign out = is_test ? {{(DATA_W-1){1'b0}}, hit} : bit_res;
endmodule

// File: rtl/alu32_shared.sv
module alu32_shared
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        op_i,
  input  logic [AMT_W-1:0]  shamt_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);
  op_grp_e           grp;
  logic [DATA_W-1:0] sh_out;
  logic [DATA_W-1:0] add_sum;
  logic              add_cin_msb;
  logic              add_cout;
  logic              add_ovf;
  logic [DATA_W-1:0] lt_out;

  assign grp = op_group(op_i);

  alu_shift_unit #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .b         (b_i),
    .amt       (shamt_i),
    .go_right  (op_is_right(op_i)),
    .sign_fill (op_is_arith_fill(op_i)),
    .shifted   (sh_out)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_add (
    .a              (a_i),
    .b              (b_i),
    .sub            (op_is_sub(op_i)),
    .sum            (add_sum),
    .carry_into_msb (add_cin_msb),
    .carry_out      (add_cout),
    .ovf            (add_ovf)
  );

  alu_logic_test #(.DATA_W(DATA_W)) u_lt (
    .a       (a_i),
    .b       (b_i),
    .sel     (op_i[2:1]),
    .is_test (op_i[0]),
    .out     (lt_out)
  );

  // Final stage: datapath half versus logic half, then bit 1 inside datapath
  always_comb begin
    unique case (grp)
      GRP_SHIFT: result_o = sh_out;
      GRP_ARITH: result_o = add_sum;
      default:   result_o = lt_out;
    endcase
  end

  assign ovf_o = (grp == GRP_ARITH) & add_ovf;
endmodule

// File: rtl/alu32_shared_chk.sv
module alu32_shared_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [3:0]        op_i,
  input logic [AMT_W-1:0]  shamt_i,
  input logic [DATA_W-1:0] result_o,
  input logic              ovf_o,
  input logic              add_cin_msb,
  input logic              add_cout
);
  always_comb begin
    // R9: flag low outside add/subtract
    if (!(op_i[3] == 1'b0 && op_i[1] == 1'b1))
      p_flag_quiet_r9: assert (ovf_o == 1'b0);
    // R9: comparisons keep the upper bits clear
    if (op_i[3] && op_i[0])
      p_test_upper_r9: assert (result_o[DATA_W-1:1] == '0);
    // R1: left shift of B
    if (op_i[3:1] == 3'b000)
      p_shl_r1: assert (result_o == (b_i << shamt_i));
    // R2: wrapped sum
    if (op_i[3:1] == 3'b001)
      p_add_wrap_r2: assert (result_o == DATA_W'(a_i + b_i));
    // R3: wrapped difference
    if (op_i[3:1] == 3'b011)
      p_sub_wrap_r3: assert (result_o == DATA_W'(a_i - b_i));
    // R2: overflow seen at the port agrees with the adder's top-bit carries
    if (op_i[3:1] == 3'b001)
      p_add_ovf_r2: assert (ovf_o == (add_cin_msb ^ add_cout));
    // R7: equality test
    if (op_i == 4'b1011)
      p_eq_r7: assert (result_o[0] == (a_i == b_i));
  end
endmodule

bind alu32_shared alu32_shared_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .op_i        (op_i),
  .shamt_i     (shamt_i),
  .result_o    (result_o),
  .ovf_o       (ovf_o),
  .add_cin_msb (add_cin_msb),
  .add_cout    (add_cout)
);

// File: tb/alu32_shared_tb.sv
module alu32_shared_tb;
  localparam int W  = 32;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]  a, b;
  logic [3:0]    op;
  logic [SW-1:0] sh;
  logic [W-1:0]  c;
  logic          v;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  alu32_shared u_dut (
    .a_i(a), .b_i(b), .op_i(op), .shamt_i(sh), .result_o(c), .ovf_o(v)
  );

  typedef struct packed {
    logic [3:0]    op;
    logic [SW-1:0] sh;
    logic [W-1:0]  a;
    logic [W-1:0]  b;
    logic [W-1:0]  c;
    logic          v;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'b0010, 5'd0,  32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1},
    '{4'b0011, 5'd0,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0},
    '{4'b0010, 5'd0,  32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1},
    '{4'b0110, 5'd0,  32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1},
    '{4'b0111, 5'd0,  32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1},
    '{4'b0110, 5'd0,  32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0},
    '{4'b0001, 5'd4,  32'h0000_0000, 32'h0000_000F, 32'h0000_00F0, 1'b0},
    '{4'b0100, 5'd4,  32'h0000_0000, 32'hF000_0000, 32'h0F00_0000, 1'b0},
    '{4'b0101, 5'd4,  32'h0000_0000, 32'hF000_0000, 32'hFF00_0000, 1'b0},
    '{4'b0101, 5'd31, 32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0},
    '{4'b1000, 5'd0,  32'hFF00_FF00, 32'h0F0F_0F0F, 32'h0F00_0F00, 1'b0},
    '{4'b1010, 5'd0,  32'hFF00_FF00, 32'h0F0F_0F0F, 32'hFF0F_FF0F, 1'b0},
    '{4'b1100, 5'd0,  32'hFF00_FF00, 32'h0F0F_0F0F, 32'hF00F_F00F, 1'b0},
    '{4'b1110, 5'd0,  32'hFF00_FF00, 32'h0F0F_0F0F, 32'h00F0_00F0, 1'b0},
    '{4'b1011, 5'd0,  32'h1234_5678, 32'h1234_5678, 32'h0000_0001, 1'b0},
    '{4'b1001, 5'd0,  32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b0},
    '{4'b1111, 5'd0,  32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{4'b1101, 5'd0,  32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 1'b0},
    '{4'b1111, 5'd0,  32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 1'b0},
    '{4'b1101, 5'd0,  32'h7FFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  localparam logic [W-1:0] CORNER [5] = '{
    32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000
  };

  // Independent reference written with language operators
  function automatic logic [W:0] model(input logic [3:0] o, input logic [SW-1:0] s,
                                       input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    logic f;
    f = 1'b0;
    casez (o)
      4'b000?: r = y << s;
      4'b001?: begin r = x + y; f = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]); end
      4'b011?: begin r = x - y; f = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]); end
      4'b0100: r = y >> s;
      4'b0101: r = $signed(y) >>> s;
      4'b1000: r = x & y;
      4'b1010: r = x | y;
      4'b1100: r = x ^ y;
      4'b1110: r = ~(x | y);
      4'b1011: r = {31'd0, x == y};
      4'b1001: r = {31'd0, x != y};
      4'b1111: r = {31'd0, $signed(x) > 0};
      default: r = {31'd0, $signed(x) <= 0};
    endcase
    return {f, r};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    casez (o)
      4'b000?: return "R1";
      4'b001?: return "R2";
      4'b011?: return "R3";
      4'b0100: return "R4";
      4'b0101: return "R5";
      4'b1??0: return "R6";
      4'b10?1: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [SW-1:0] s,
                       input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    #1;
    op = o; sh = s; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W-1:0] exp_c, input logic exp_v);
    checks++;
    if (c !== exp_c || v !== exp_v) begin
      errors++;
      $display("FAIL %s op=%b sh=%0d a=%h b=%h: got c=%h v=%b, expected c=%h v=%b",
               tag, op, sh, a, b, c, v, exp_c, exp_v);
    end
  endtask

  task automatic run_model(input logic [3:0] o, input logic [SW-1:0] s,
                           input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] e;
    e = model(o, s, x, y);
    drive(o, s, x, y);
    check(tag_of(o), e[W-1:0], e[W]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op = '0; sh = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", '0, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].sh, VECS[i].a, VECS[i].b);
      check(tag_of(VECS[i].op), VECS[i].c, VECS[i].v);
    end

    // Every shift count for R1, R4, R5 on two patterns
    for (int s = 0; s < 32; s++) begin
      run_model(4'b0000, SW'(s), 32'h0, 32'h8000_0001);
      run_model(4'b0100, SW'(s), 32'h0, 32'h8000_0001);
      run_model(4'b0101, SW'(s), 32'h0, 32'h8000_0001);
      run_model(4'b0101, SW'(s), 32'h0, 32'h4C3B_2A19);
    end

    // Corner operand pairs on arithmetic and tests (R2, R3, R7, R8, R9)
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        run_model(4'b0010, 5'd0, CORNER[i], CORNER[j]);
        run_model(4'b0110, 5'd0, CORNER[i], CORNER[j]);
        run_model(4'b1011, 5'd0, CORNER[i], CORNER[j]);
        run_model(4'b1001, 5'd0, CORNER[i], CORNER[j]);
        run_model(4'b1111, 5'd0, CORNER[i], CORNER[j]);
        run_model(4'b1101, 5'd0, CORNER[i], CORNER[j]);
      end

    // Every opcode; R9 flag and upper bits come from the model
    for (int o = 0; o < 16; o++) begin
      run_model(4'(o), 5'd7, 32'hDEAD_BEEF, 32'h7654_3210);
      run_model(4'(o), 5'd13, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    end

    // R10: don't-care bit 0 gives identical outputs
    for (int g = 0; g < 3; g++) begin
      logic [3:0] base;
      logic [W-1:0] c0;
      logic v0;
      base = (g == 0) ? 4'b0000 : (g == 1) ? 4'b0010 : 4'b0110;
      drive(base, 5'd9, 32'h8000_0000, 32'hC000_0003);
      c0 = c; v0 = v;
      drive(base | 4'b0001, 5'd9, 32'h8000_0000, 32'hC000_0003);
      check("R10 dont-care bit", c0, v0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule